// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

The block is a 32-bit down-counter fed by a power-of-two prescaler. Software programs three things through a simple write port: a control entry, a divide setting and a start value. The control entry holds an interrupt vector, a mask bit and a repeat bit. Writing the start value restarts both the counter and the prescaler. The counter then falls by one on every divided tick.

When the count expires, the block emits a one-cycle interrupt request carrying the vector. In one-shot mode this happens once. In repeat mode it happens every start+1 ticks, with the counter reloading each time.

The live count and every register can be read back combinationally through the same address lines. The interrupt output is a valid-only stream with no ready. Each request is a single-cycle strobe that the consumer must take in that cycle, so back-pressure is not possible. The strobe is always edge-type: it never stays high.

Top module: `cdt_timer`

## Requirements
- R1: After reset, the control entry reads 0x0001_0000 (masked), and the start value, live count and divide setting all read 0. The interrupt strobe is low.
- R2: A write to the divide register stores only bits 3, 1 and 0 of the data. Writing 0xFFFF_FFFF reads back as 0xB.
- R3: The divide code is {bit3, bit1, bit0} of the divide register. Ticks are spaced 2^((code+1) mod 8) clock cycles apart, so code 7 means every cycle and codes 0 to 6 mean 2 to 128 cycles.
- R4: With repeat bit 17 clear, the live count falls by one per tick from the start value and holds at 0. One strobe appears start+1 ticks after the load, and no further strobe follows. A start value of 0 never strikes.
- R5: With repeat bit 17 set, the count runs from the start value down to 0 and reloads. A strobe appears every start+1 ticks. A start value of 0 never strikes.
- R6: While mask bit 16 of the entry is set, no strobe is produced, but the count keeps running.
- R7: The strobe lasts one cycle, and irq_vector holds entry bits 7:0 as they stood at expiry.
- R8: Writing the start value (address 1) restarts the count from that value and restarts the prescaler phase in the same cycle.
- R9: Rewriting the control entry (address 0) does not reload or disturb the count.
- R10: A write to the live-count address (2) has no effect. The divide register sits at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read: 0 entry, 1 start, 2 live count, 3 divide |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for reg_addr |
| irq_valid | output | 1 | One-cycle interrupt strobe |
| irq_vector | output | 8 | Vector of the last strobe |

## Verification
The bench measures strike spacing at all eight divide codes and catches a wrong code mapping or an off-by-one period (start instead of start+1 ticks). Zero start values in both modes are exercised: a design that treats zero as a wrap of 2^32, or that strikes at once, would produce a strobe there. A reload in mid-count with a slow divider shows whether the prescaler phase is restarted, since a stale phase makes the strike come early. Rewriting the entry in mid-count checks that the count is not reloaded and that the vector is sampled at expiry rather than at load.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DATA_W       = 32;
  localparam int VEC_W        = 8;
  localparam int MASK_BIT     = 16;
  localparam int PERIODIC_BIT = 17;
  localparam int SHIFT_W      = 3;
  localparam logic [3:0]        DIV_KEEP  = 4'hB;
  localparam logic [DATA_W-1:0] ENTRY_RST = 32'h0001_0000;

  typedef enum logic [1:0] {
    REG_ENTRY = 2'd0,
    REG_START = 2'd1,
    REG_LIVE  = 2'd2,
    REG_DIV   = 2'd3
  } cdt_reg_e;

  // code is {bit3, bit1, bit0} of the divide register; shift wraps mod 8
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [SHIFT_W-1:0] code);
    return SHIFT_W'(code + SHIFT_W'(1));
  endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] entry_q,
  output logic [CNT_W-1:0]  start_q,
  output logic [3:0]        div_q,
  output logic              load
);
  assign load = wr_en && (cdt_reg_e'(reg_addr) == REG_START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q <= ENTRY_RST;
      start_q <= '0;
      div_q   <= '0;
    end else if (wr_en) begin
      case (cdt_reg_e'(reg_addr))
        REG_ENTRY: entry_q <= wr_data;
        REG_START: start_q <= wr_data[CNT_W-1:0];
        REG_DIV:   div_q   <= wr_data[3:0] & DIV_KEEP;
        default:   ; // live count is read-only
      endcase
    end
  end
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   limit;

  assign limit = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
  assign tick  = ({1'b0, pre_q} >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)              pre_q <= '0;
    else if (restart || tick) pre_q <= '0;
    else                     pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign count   = cnt_q;
  assign expire  = tick && at_zero && !load && (start_val != '0) && (periodic || armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      armed_q <= (load_val != '0);
    end else if (tick) begin
      if (at_zero) begin
        armed_q <= 1'b0;
        if (periodic) cnt_q <= start_val;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [DATA_W-1:0]  entry_word;
  logic [CNT_W-1:0]   start_cnt;
  logic [CNT_W-1:0]   cur_cnt;
  logic [3:0]         div_cfg;
  logic               load_we;
  logic               tick;
  logic               expire;
  logic               entry_mask;
  logic               entry_periodic;
  logic [SHIFT_W-1:0] shift;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;

  cdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .entry_q(entry_word), .start_q(start_cnt),
    .div_q(div_cfg), .load(load_we)
  );

  assign entry_mask     = entry_word[MASK_BIT];
  assign entry_periodic = entry_word[PERIODIC_BIT];
  assign shift          = div_shift({div_cfg[3], div_cfg[1:0]});

  cdt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load_we), .shift(shift), .tick(tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load_we),
    .load_val(wr_data[CNT_W-1:0]), .start_val(start_cnt),
    .periodic(entry_periodic), .count(cur_cnt), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= expire && !entry_mask;
      if (expire) vec_q <= entry_word[VEC_W-1:0];
    end
  end

  assign irq_valid  = irq_q;
  assign irq_vector = vec_q;

  always_comb begin
    case (cdt_reg_e'(reg_addr))
      REG_ENTRY: rd_data = entry_word;
      REG_START: rd_data = DATA_W'(start_cnt);
      REG_LIVE:  rd_data = DATA_W'(cur_cnt);
      default:   rd_data = DATA_W'(div_cfg);
    endcase
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_we,
  input logic             irq_valid,
  input logic             entry_mask,
  input logic             entry_periodic,
  input logic [CNT_W-1:0] cur_cnt,
  input logic [CNT_W-1:0] start_cnt,
  input logic             div_bit2
);
  assert_div_bit2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_bit2 == 1'b0);

  assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && !entry_periodic && cur_cnt == '0) |=> (cur_cnt == '0));

  assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(entry_mask));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_we |=> (cur_cnt == $past(cur_cnt) ||
                  cur_cnt == $past(cur_cnt) - CNT_W'(1) ||
                  cur_cnt == $past(start_cnt)));
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_we(load_we), .irq_valid(irq_valid),
  .entry_mask(entry_mask), .entry_periodic(entry_periodic),
  .cur_cnt(cur_cnt), .start_cnt(start_cnt), .div_bit2(div_cfg[2])
);

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  int checks = 0;
  int errors = 0;

  localparam logic [1:0] A_ENTRY = 2'd0, A_START = 2'd1, A_LIVE = 2'd2, A_DIV = 2'd3;

  // {divide[20:17], start[16:9], repeat[8], vector[7:0]}
  localparam logic [20:0] VEC_TAB [0:7] = '{
    {4'hB, 8'd5, 1'b0, 8'h21},
    {4'h0, 8'd3, 1'b0, 8'h42},
    {4'h1, 8'd2, 1'b1, 8'h63},
    {4'h2, 8'd1, 1'b0, 8'h84},
    {4'h3, 8'd1, 1'b1, 8'hA5},
    {4'h8, 8'd2, 1'b0, 8'hC6},
    {4'h9, 8'd1, 1'b0, 8'hE7},
    {4'hA, 8'd1, 1'b1, 8'hF8}
  };

  cdt_timer u_cdt_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write is taken at the next rising edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (irq_valid) begin
        n = k;
        break;
      end
    end
  endtask

  function automatic int exp_period(input logic [3:0] d, input int start);
    int sh;
    sh = (int'({d[3], d[1:0]}) + 1) % 8;
    return (start + 1) << sh;
  endfunction

  initial begin
    logic [31:0] rv;
    int n;
    int p;
    logic [3:0] dv;
    int sv;
    logic pv;
    logic [7:0] vv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(A_ENTRY, rv); check_eq("R1 entry reset", rv, 32'h0001_0000);
    peek(A_START, rv); check_eq("R1 start reset", rv, 32'd0);
    peek(A_LIVE, rv);  check_eq("R1 live reset", rv, 32'd0);
    peek(A_DIV, rv);   check_eq("R1 divide reset", rv, 32'd0);
    check_eq("R1 strobe low", {31'd0, irq_valid}, 32'd0);

    // R10 live-count address ignores writes
    wr(A_LIVE, 32'h1234);
    peek(A_LIVE, rv);  check_eq("R10 live unchanged", rv, 32'd0);
    peek(A_START, rv); check_eq("R10 start unchanged", rv, 32'd0);

    // R2 divide keeps bits 3,1,0
    wr(A_DIV, 32'hFFFF_FFFF);
    peek(A_DIV, rv); check_eq("R2 divide masking", rv, 32'hB);

    // table walk: R3 spacing, R4/R5 modes, R7 vector and width
    for (int i = 0; i < 8; i++) begin
      dv = VEC_TAB[i][20:17];
      sv = int'(VEC_TAB[i][16:9]);
      pv = VEC_TAB[i][8];
      vv = VEC_TAB[i][7:0];
      p  = exp_period(dv, sv);
      wr(A_DIV, {28'd0, dv});
      wr(A_ENTRY, {14'd0, pv, 1'b0, 8'd0, vv});
      wr(A_START, sv);
      wait_irq(p + 4, n);
      check_eq($sformatf("R3 first strike row %0d", i), n, p);
      check_eq($sformatf("R7 vector row %0d", i), {24'd0, irq_vector}, {24'd0, vv});
      @(negedge clk);
      check_eq($sformatf("R7 one-cycle strobe row %0d", i), {31'd0, irq_valid}, 32'd0);
      if (pv) begin
        wait_irq(p + 4, n);
        check_eq($sformatf("R5 repeat spacing row %0d", i), n, p - 1);
      end else begin
        wait_irq(2 * p, n);
        check_eq($sformatf("R4 no second strike row %0d", i), n, 0);
      end
      wr(A_ENTRY, 32'h0001_0000);
    end

    // R4 live count readback and hold at zero
    wr(A_DIV, 32'hB);
    wr(A_ENTRY, 32'h0000_0011);
    wr(A_START, 32'd10);
    repeat (3) @(negedge clk);
    peek(A_LIVE, rv); check_eq("R4 live count falls", rv, 32'd7);
    wait_irq(20, n);  check_eq("R4 strike after start+1 ticks", n, 8);
    peek(A_LIVE, rv); check_eq("R4 live holds zero", rv, 32'd0);

    // R4 one-shot start of zero never strikes
    wr(A_START, 32'd0);
    wait_irq(50, n); check_eq("R4 zero start one-shot silent", n, 0);

    // R5 repeat start of zero never strikes
    wr(A_ENTRY, 32'h0002_0077);
    wr(A_START, 32'd0);
    wait_irq(50, n); check_eq("R5 zero start repeat silent", n, 0);
    peek(A_LIVE, rv); check_eq("R5 zero start live", rv, 32'd0);

    // R6 mask suppresses strobe while counting continues
    wr(A_ENTRY, 32'h0003_0099);
    wr(A_START, 32'd3);
    repeat (6) @(negedge clk);
    peek(A_LIVE, rv); check_eq("R6 masked count runs", rv, 32'd1);
    wait_irq(20, n); check_eq("R6 masked no strobe", n, 0);

    // R9 entry rewrite does not reload; vector taken at expiry (R7)
    wr(A_ENTRY, 32'h0000_0033);
    wr(A_START, 32'd20);
    repeat (5) @(negedge clk);
    peek(A_LIVE, rv); check_eq("R9 count before rewrite", rv, 32'd15);
    wr(A_ENTRY, 32'h0000_0055);
    peek(A_LIVE, rv); check_eq("R9 count after rewrite", rv, 32'd14);
    wait_irq(30, n);  check_eq("R9 strike time kept", n, 15);
    check_eq("R7 vector at expiry", {24'd0, irq_vector}, 32'h55);

    // R8 reload restarts count and prescaler phase (divide by 8)
    wr(A_DIV, 32'h2);
    wr(A_START, 32'd1);
    repeat (5) @(negedge clk);
    wr(A_START, 32'd1);
    wait_irq(40, n); check_eq("R8 restart with fresh phase", n, 16);

    finish_run();
  end
endmodule